// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the partial remainders of a binary BCH code over GF(2^13) into the complete syndrome set S1..S2t that an error-locator solver consumes. Up to 24 remainders of 16 bits each arrive packed two to a 32-bit word in one wide image. After a start pulse, the unit computes the odd syndromes by evaluating each remainder at a power of the primitive element. It then derives every even syndrome by squaring an earlier one, which binary BCH codes allow. A one-cycle done pulse marks the moment the registered syndrome array is complete.

All field arithmetic is combinational logic over the primitive polynomial x^13 + x^4 + x^3 + x + 1. The unit uses no lookup tables. The correction capability t is chosen per job through a small code. The unit spends t cycles on odd syndromes and t cycles on even syndromes, so a job finishes 2t cycles after it is accepted.

Top module: `bch_syndrome_expander`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o and done_o are low and every syndrome entry is zero.
- R2: cap_code_i selects t: 0 gives 2, 1 gives 4, 2 gives 8, 3 gives 12, and 4 to 7 all give 24.
- R3: Remainder i (0-based) sits at bits [16i+15:16i] of rem_image_i, which is the upper half of word i/2 when i is odd and the lower half when i is even. Only its bits 0..12 matter, so bits 13..15 of each remainder have no effect.
- R4: For i = 0..t-1, syndrome S(2i+1) is the XOR, over every set bit j of remainder i, of alpha^((2i+1)·j) with exponents modulo 8191, in the field generated by x^13 + x^4 + x^3 + x + 1 (alpha = 2).
- R5: For j = 1..t, S(2j) equals S(j) squared in that field, and a zero S(j) yields a zero S(2j).
- R6: When done_o is high, every entry with index above 2t is zero, including entries left by an earlier job with a larger t.
- R7: done_o is high for exactly one cycle, and it first rises 2t rising edges after the edge that accepts start_i. busy_o is high from the accepting edge until done_o rises, and it falls at the same edge.
- R8: A start_i pulse while busy_o is high is ignored, so the running job's result is unchanged.
- R9: cap_code_i and rem_image_i are sampled only at the accepting edge. Changes to them later in the job do not alter the result.
- R10: Syndrome S(k) (1-based) is presented at bits [13k-1:13k-13] of syndromes_o and holds its value after done_o until the next job is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| cap_code_i | input | 3 | Correction capability code |
| rem_image_i | input | 384 | Packed partial remainders, two per 32-bit word |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| syndromes_o | output | 624 | Syndromes S1..S48, 13 bits each |

## Verification
The assertions assume that start_i is a single-cycle pulse and that cap_code_i is one of its eight legal 3-bit values. They also assume that rem_image_i holds steady during the edge that accepts a job. The directed tasks drive every input at the falling edge and release start_i after one cycle. The tasks also raise start_i and change the image and code in mid-job on purpose, so that the guarded paths still meet only well-formed stimulus.

// File: rtl/syn_pkg.sv
package syn_pkg;

  localparam int GF_M = 13;
  localparam logic [GF_M:0] GF_POLY = 14'h201B;

  function automatic logic [GF_M-1:0] gf_xtime(input logic [GF_M-1:0] a);
    logic [GF_M-1:0] r;
    r = {a[GF_M-2:0], 1'b0};
    if (a[GF_M-1]) r = r ^ GF_POLY[GF_M-1:0];
    return r;
  endfunction

  function automatic logic [GF_M-1:0] gf_xtime_n(input logic [GF_M-1:0] a, input int n);
    logic [GF_M-1:0] r;
    r = a;
    for (int s = 0; s < n; s++) r = gf_xtime(r);
    return r;
  endfunction

  // Squaring is linear over GF(2): spread the bits to even positions, then reduce.
  function automatic logic [GF_M-1:0] gf_square(input logic [GF_M-1:0] a);
    logic [2*GF_M-2:0] p;
    p = '0;
    for (int i = 0; i < GF_M; i++) p[2*i] = a[i];
    for (int i = 2*GF_M-2; i >= GF_M; i--) begin
      if (p[i]) p[i-GF_M +: GF_M+1] = p[i-GF_M +: GF_M+1] ^ GF_POLY;
    end
    return p[GF_M-1:0];
  endfunction

  function automatic int cap_to_t(input logic [2:0] code);
    case (code)
      3'd0:    return 2;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 12;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/syn_ctrl.sv
module syn_ctrl #(
  parameter int TMAX = 24,
  parameter int KW   = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [2:0]    cap_code_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          load_o,
  output logic          odd_o,
  output logic          even_o,
  output logic [KW-1:0] k_o,
  output logic [KW-1:0] t_o
);
  import syn_pkg::*;

  typedef enum logic [1:0] {ST_IDLE, ST_ODD, ST_EVEN} phase_e;

  phase_e        state_q;
  logic [KW-1:0] k_q;
  logic [KW-1:0] t_q;
  logic          done_q;
  logic [KW-1:0] t_sel;

  always_comb begin
    int tv;
    tv = cap_to_t(cap_code_i);
    if (tv > TMAX) tv = TMAX;
    t_sel = KW'(tv);
  end

  assign load_o = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      t_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_ODD;
            k_q     <= '0;
            t_q     <= t_sel;
          end
        end
        ST_ODD: begin
          if (k_q == t_q - KW'(1)) begin
            state_q <= ST_EVEN;
            k_q     <= KW'(1);
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        ST_EVEN: begin
          if (k_q == t_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            k_q     <= '0;
          end else begin
            k_q <= k_q + KW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign odd_o  = (state_q == ST_ODD);
  assign even_o = (state_q == ST_EVEN);
  assign k_o    = k_q;
  assign t_o    = t_q;

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o);

  // R7: busy only drops together with a completion pulse
  p_busy_fall_r7: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> done_o);

  // R2: odd evaluation never runs past the selected capability
  p_odd_range_r2: assert property (@(posedge clk) disable iff (rst) odd_o |-> (k_o < t_o));

  // R8: capability is frozen for the whole job, whatever start does
  p_cap_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(t_o));

endmodule

// File: rtl/syn_odd_eval.sv
module syn_odd_eval #(
  parameter int M = syn_pkg::GF_M
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [M-1:0] rem_i,
  output logic [M-1:0] val_o
);
  import syn_pkg::*;

  // pw_q[j] holds alpha^(i*j) for the odd index i being evaluated
  logic [M-1:0] pw_q [M];

  for (genvar j = 0; j < M; j++) begin : g_pow
    always_ff @(posedge clk) begin
      if (rst || load_i) begin
        pw_q[j] <= {{(M-1){1'b0}}, 1'b1} << j;
      end else if (step_i) begin
        pw_q[j] <= gf_xtime_n(pw_q[j], 2 * j);
      end
    end
  end

  always_comb begin
    val_o = '0;
    for (int j = 0; j < M; j++) begin
      if (rem_i[j]) val_o = val_o ^ pw_q[j];
    end
  end

  // R4: the bit-0 term is alpha^0 for every odd index
  p_unit_power_r4: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (pw_q[0] == {{(M-1){1'b0}}, 1'b1}));

endmodule

// File: rtl/syn_store.sv
module syn_store #(
  parameter int M  = syn_pkg::GF_M,
  parameter int NS = 48,
  parameter int AW = $clog2(NS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [M-1:0]    wr_data_i,
  input  logic [AW-1:0]   rd_addr_i,
  output logic [M-1:0]    rd_data_o,
  output logic [NS*M-1:0] all_o
);

  logic [M-1:0] mem_q [NS];

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      for (int e = 0; e < NS; e++) mem_q[e] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = (int'(rd_addr_i) < NS) ? mem_q[rd_addr_i] : '0;

  for (genvar e = 0; e < NS; e++) begin : g_out
    assign all_o[e*M +: M] = mem_q[e];
  end

  // R10: every write lands inside the syndrome array
  p_wr_range_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> (int'(wr_addr_i) < NS));

endmodule

// File: rtl/bch_syndrome_expander.sv
module bch_syndrome_expander #(
  parameter  int TMAX = 24,
  parameter  int RW   = 16,
  parameter  int WW   = 32,
  parameter  int M    = syn_pkg::GF_M,
  localparam int NW   = (TMAX * RW + WW - 1) / WW,
  localparam int NS   = 2 * TMAX
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       cap_code_i,
  input  logic [NW*WW-1:0] rem_image_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NS*M-1:0]  syndromes_o
);
  import syn_pkg::*;

  localparam int KW = $clog2(TMAX + 1);
  localparam int AW = $clog2(NS);

  logic          load, odd, even;
  logic [KW-1:0] k, t;
  logic [M-1:0]  rem_q [TMAX];
  logic [M-1:0]  rem_cur;
  logic [M-1:0]  odd_val;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [M-1:0]  wr_data, rd_data;
  logic          tail_nz;

  syn_ctrl #(.TMAX(TMAX), .KW(KW)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .cap_code_i(cap_code_i),
    .busy_o(busy_o), .done_o(done_o), .load_o(load), .odd_o(odd),
    .even_o(even), .k_o(k), .t_o(t)
  );

  // Keep only the field-width bits of each remainder, captured at job start
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TMAX; i++) rem_q[i] <= '0;
    end else if (load) begin
      for (int i = 0; i < TMAX; i++) rem_q[i] <= rem_image_i[i*RW +: M];
    end
  end

  assign rem_cur = (int'(k) < TMAX) ? rem_q[k] : '0;

  syn_odd_eval #(.M(M)) u_odd (
    .clk(clk), .rst(rst), .load_i(load), .step_i(odd),
    .rem_i(rem_cur), .val_o(odd_val)
  );

  always_comb begin
    wr_addr = '0;
    wr_data = '0;
    rd_addr = AW'(int'(k) - 1);
    if (odd) begin
      wr_addr = AW'(2 * int'(k));
      wr_data = odd_val;
    end else if (even) begin
      wr_addr = AW'(2 * int'(k) - 1);
      wr_data = gf_square(rd_data);
    end
  end

  syn_store #(.M(M), .NS(NS), .AW(AW)) u_store (
    .clk(clk), .rst(rst), .clear_i(load), .wr_en_i(odd || even),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .all_o(syndromes_o)
  );

  always_comb begin
    tail_nz = 1'b0;
    for (int e = 0; e < NS; e++) begin
      if ((e >= 2 * int'(t)) && (syndromes_o[e*M +: M] != '0)) tail_nz = 1'b1;
    end
  end

  // R6: nothing above index 2t survives to completion
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (rst) done_o |-> !tail_nz);

endmodule

// File: tb/test_bch_syndrome_expander.sv
module test_bch_syndrome_expander;

  localparam int TMAX = 24;
  localparam int NS   = 48;
  localparam int IMGW = 384;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_i = 1'b0;
  logic [2:0]      cap_code_i = '0;
  logic [IMGW-1:0] rem_image_i = '0;
  logic            busy_o, done_o;
  logic [NS*13-1:0] syndromes_o;

  int checks = 0;
  int errors = 0;
  logic [12:0] exp_s [1:NS];
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  bch_syndrome_expander i_bch_syndrome_expander (
    .clk(clk), .rst(rst), .start_i(start_i), .cap_code_i(cap_code_i),
    .rem_image_i(rem_image_i), .busy_o(busy_o), .done_o(done_o),
    .syndromes_o(syndromes_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [12:0] rmul(input logic [12:0] a, input logic [12:0] b);
    logic [12:0] p = '0;
    logic [12:0] x = a;
    logic [13:0] sh;
    for (int i = 0; i < 13; i++) begin
      if (b[i]) p = p ^ x;
      sh = {x, 1'b0};
      if (sh[13]) sh = sh ^ 14'h201B;
      x = sh[12:0];
    end
    return p;
  endfunction

  function automatic logic [12:0] apow(input int e);
    logic [12:0] r = 13'd1;
    for (int s = 0; s < (e % 8191); s++) r = rmul(r, 13'd2);
    return r;
  endfunction

  function automatic int code_t(input logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 24;
    endcase
  endfunction

  task automatic build_expected(input logic [2:0] code, input logic [IMGW-1:0] img);
    int t = code_t(code);
    logic [15:0] rm;
    logic [12:0] s;
    for (int e = 1; e <= NS; e++) exp_s[e] = '0;
    for (int i = 0; i < t; i++) begin
      rm = img[16*i +: 16];
      s = '0;
      for (int j = 0; j < 13; j++) if (rm[j]) s = s ^ apow((2*i+1) * j);
      exp_s[2*i+1] = s;
    end
    for (int k = 1; k <= t; k++) exp_s[2*k] = rmul(exp_s[k], exp_s[k]);
  endtask

  function automatic logic [IMGW-1:0] rand_img();
    logic [IMGW-1:0] v;
    for (int w = 0; w < IMGW/32; w++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      v[32*w +: 32] = rng;
    end
    return v;
  endfunction

  // One job: start, optional mid-job disturbance (R8, R9), latency and full result check.
  task automatic run_job(input string name, input logic [2:0] code,
                         input logic [IMGW-1:0] img, input bit disturb);
    int t = code_t(code);
    int n = 0;
    build_expected(code, img);
    @(negedge clk);
    start_i = 1'b1; cap_code_i = code; rem_image_i = img;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      rem_image_i = ~img;
      cap_code_i = 3'd0;
    end
    chk("R7", {name, " busy after accept"}, busy_o, 1);
    while (!done_o && n < 200) begin
      @(negedge clk);
      n++;
      start_i = (disturb && n == 2);
    end
    start_i = 1'b0;
    chk("R7", {name, " latency"}, n, 2*t);
    chk("R7", {name, " busy low at done"}, busy_o, 0);
    for (int e = 1; e <= NS; e++) begin
      string req;
      if (e > 2*t) req = "R6";
      else if (e % 2 == 1) req = "R4";
      else req = "R5";
      chk(req, $sformatf("%s S%0d", name, e), syndromes_o[(e-1)*13 +: 13], exp_s[e]);
    end
    @(negedge clk);
    chk("R7", {name, " done one cycle"}, done_o, 0);
    chk("R10", {name, " S1 held"}, syndromes_o[12:0], exp_s[1]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy_o, 0);
    chk("R1", "done in reset", done_o, 0);
    chk("R1", "syndromes in reset", (syndromes_o == '0), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "syndromes after reset", (syndromes_o == '0), 1);
  endtask

  task automatic t_small_bits();
    logic [IMGW-1:0] img = '0;
    img[0]  = 1'b1;            // remainder 0 = alpha^0 term
    img[16 + 1] = 1'b1;        // remainder 1, bit 1 (upper half of word 0, R3)
    run_job("t2_bits", 3'd0, img, 1'b0);
    chk("R4", "S1 is one", syndromes_o[12:0], 13'd1);
  endtask

  task automatic t_zero();
    run_job("zero_t24", 3'd4, '0, 1'b0);
  endtask

  task automatic t_high_bits();
    logic [IMGW-1:0] img = '0;
    for (int i = 0; i < TMAX; i++) img[16*i + 13 +: 3] = 3'b111;
    run_job("R3_hibits", 3'd4, img, 1'b0);
    chk("R3", "upper bits ignored", (syndromes_o == '0), 1);
  endtask

  task automatic t_caps();
    run_job("cap4", 3'd1, rand_img(), 1'b0);
    run_job("cap8", 3'd2, rand_img(), 1'b0);
    run_job("cap12", 3'd3, rand_img(), 1'b0);
    run_job("cap24", 3'd4, rand_img(), 1'b0);
  endtask

  task automatic t_tail_clear();
    run_job("big", 3'd4, rand_img(), 1'b0);
    run_job("R6_small_after_big", 3'd0, rand_img(), 1'b0);
  endtask

  task automatic t_alias_codes();
    run_job("R2_code6", 3'd6, rand_img(), 1'b0);
    run_job("R2_code7", 3'd7, rand_img(), 1'b0);
  endtask

  task automatic t_disturb();
    run_job("R8_R9_disturb", 3'd3, rand_img(), 1'b1);
  endtask

  initial begin
    t_reset();
    t_small_bits();
    t_zero();
    t_high_bits();
    t_caps();
    t_tail_clear();
    t_alias_codes();
    t_disturb();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule